// File: doc/BRIEF.md
# Return-from-Interrupt State Restore Unit

This block carries out the final step of every return-from-interrupt operation in a processor core. When the pipeline retires a return instruction, it presents the return flavour together with the contents of the saved-address and saved-state register pairs. The unit picks the pair that belongs to that flavour and applies the state mask that flavour demands. It then produces the program counter and machine-state value the core resumes with.

The normal return depends on the core's architecture mode: a classic 32-bit style, a server 64-bit style or an embedded style. The other flavours each have a fixed rule. A 64-bit-mode indicator tells the unit whether the resumed context runs wide. When it does not, the restored state is cut to 32 bits. For the classic normal return, the upper half of the current machine state is then merged back in. Each accepted return also raises a one-cycle flush strobe, so that prefetched or translated work is thrown away. Register storage and instruction decode stay outside the block.

Top module: `rfi_restore`

## Requirements
- R1: The restored PC equals the selected saved address with bits 1 and 0 forced to zero; all other bits pass unchanged.
- R2: Flavour code 1 (normal, uses the normal pair) in arch mode 0 (classic) clears state bits 0x783F0000; with a 32-bit target the upper 32 bits come from the current machine state.
- R3: Flavour code 1 in arch mode 2 (embedded), and flavours 3 (critical pair), 4 (debug pair) and 5 (machine-check pair) pass the saved state through unmasked.
- R4: Flavour code 1 in arch mode 1 (server) and flavour 2 (hypervisor pair) clear state bits 0x783F0000 and never keep the current upper half.
- R5: Flavour code 6 (legacy critical pair) clears state bits 0xFFFF0000.
- R6: Flavour code 7 (legacy system-call return) takes the address from the link register and the state from the count register, keeping only bits 15:0 of the state.
- R7: When the 64-bit-mode indicator is low, the masked state is truncated to 32 bits. Bits 63:32 are then zero unless R2 asks for the current upper half.
- R8: PC, state and flush are registered. An accepted return on one clock edge shows its results after that edge, with flush high for exactly that cycle.
- R9: Flavour code 0, or flavour 1 with arch mode 3, and any cycle without a valid strobe, raise no flush and leave PC and state unchanged.
- R10: After reset the PC and state outputs are zero and flush is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfi_valid | input | 1 | Return operation strobe |
| rfi_kind | input | 3 | Return flavour code |
| arch_mode | input | 2 | Architecture style for the normal return |
| tgt_wide | input | 1 | Resumed context runs in 64-bit mode |
| cur_msr | input | XLEN | Current machine state |
| save_pc_norm | input | XLEN | Normal saved address |
| save_st_norm | input | XLEN | Normal saved state |
| save_pc_hyp | input | XLEN | Hypervisor saved address |
| save_st_hyp | input | XLEN | Hypervisor saved state |
| save_pc_crit | input | XLEN | Critical saved address |
| save_st_crit | input | XLEN | Critical saved state |
| save_pc_dbg | input | XLEN | Debug saved address |
| save_st_dbg | input | XLEN | Debug saved state |
| save_pc_mchk | input | XLEN | Machine-check saved address |
| save_st_mchk | input | XLEN | Machine-check saved state |
| save_pc_lcrit | input | XLEN | Legacy critical saved address |
| save_st_lcrit | input | XLEN | Legacy critical saved state |
| link_reg | input | XLEN | Link register, address for the system-call return |
| count_reg | input | XLEN | Count register, state for the system-call return |
| next_pc | output | XLEN | Restored program counter |
| next_msr | output | XLEN | Restored machine state |
| flush | output | 1 | Pipeline flush strobe |

## Verification
The bench builds the block with its default XLEN of 64. At that width the upper-half merge, the 32-bit truncation and the difference between masks that only touch the low word all become visible. Every flavour is swept against every arch mode and both target widths, including the two reserved combinations. Saved values use random data with both low address bits set, so masking and alignment errors show up in the output.

// File: rtl/rfi_restore_pkg.sv
package rfi_restore_pkg;

  typedef enum logic [2:0] {
    RK_NONE   = 3'd0,
    RK_NORMAL = 3'd1,
    RK_HYPER  = 3'd2,
    RK_CRIT   = 3'd3,
    RK_DEBUG  = 3'd4,
    RK_MCHK   = 3'd5,
    RK_LCRIT  = 3'd6,
    RK_SYSRET = 3'd7
  } rfi_kind_e;

  typedef enum logic [1:0] {
    AM_CLASSIC  = 2'd0,
    AM_SERVER   = 2'd1,
    AM_EMBEDDED = 2'd2,
    AM_RSVD     = 2'd3
  } arch_mode_e;

  typedef enum logic [1:0] {
    MS_ALL     = 2'd0,
    MS_CLASSIC = 2'd1,
    MS_LCRIT   = 2'd2,
    MS_LOW16   = 2'd3
  } mask_sel_e;

  typedef struct packed {
    logic      legal;
    logic      keep_hi;
    mask_sel_e msel;
  } rfi_ctl_t;

  localparam logic [31:0] CLASSIC_CLEAR = 32'h783F_0000;
  localparam logic [31:0] LCRIT_CLEAR   = 32'hFFFF_0000;
  localparam logic [31:0] LOW16_KEEP    = 32'h0000_FFFF;

  // Flavour + arch mode -> mask choice, upper-half policy, legality
  function automatic rfi_ctl_t decode_ctl(input logic [2:0] kind, input logic [1:0] mode);
    rfi_ctl_t c;
    c.legal   = 1'b1;
    c.keep_hi = 1'b0;
    c.msel    = MS_ALL;
    case (kind)
      RK_NORMAL: begin
        case (mode)
          AM_CLASSIC:  begin c.msel = MS_CLASSIC; c.keep_hi = 1'b1; end
          AM_SERVER:   c.msel = MS_CLASSIC;
          AM_EMBEDDED: c.msel = MS_ALL;
          default:     c.legal = 1'b0;
        endcase
      end
      RK_HYPER:  c.msel = MS_CLASSIC;
      RK_CRIT,
      RK_DEBUG,
      RK_MCHK:   c.msel = MS_ALL;
      RK_LCRIT:  c.msel = MS_LCRIT;
      RK_SYSRET: c.msel = MS_LOW16;
      default:   c.legal = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rfi_pair_select.sv
module rfi_pair_select #(
  parameter int XLEN = 64
) (
  input  logic [2:0]      kind,
  input  logic [XLEN-1:0] pc_norm,
  input  logic [XLEN-1:0] st_norm,
  input  logic [XLEN-1:0] pc_hyp,
  input  logic [XLEN-1:0] st_hyp,
  input  logic [XLEN-1:0] pc_crit,
  input  logic [XLEN-1:0] st_crit,
  input  logic [XLEN-1:0] pc_dbg,
  input  logic [XLEN-1:0] st_dbg,
  input  logic [XLEN-1:0] pc_mchk,
  input  logic [XLEN-1:0] st_mchk,
  input  logic [XLEN-1:0] pc_lcrit,
  input  logic [XLEN-1:0] st_lcrit,
  input  logic [XLEN-1:0] pc_link,
  input  logic [XLEN-1:0] st_count,
  output logic [XLEN-1:0] sel_pc,
  output logic [XLEN-1:0] sel_st
);
  import rfi_restore_pkg::*;

  localparam int NKIND = 8;

  logic [XLEN-1:0] pc_tab [NKIND];
  logic [XLEN-1:0] st_tab [NKIND];

  always_comb begin
    pc_tab[RK_NONE]   = '0;            st_tab[RK_NONE]   = '0;
    pc_tab[RK_NORMAL] = pc_norm;       st_tab[RK_NORMAL] = st_norm;
    pc_tab[RK_HYPER]  = pc_hyp;        st_tab[RK_HYPER]  = st_hyp;
    pc_tab[RK_CRIT]   = pc_crit;       st_tab[RK_CRIT]   = st_crit;
    pc_tab[RK_DEBUG]  = pc_dbg;        st_tab[RK_DEBUG]  = st_dbg;
    pc_tab[RK_MCHK]   = pc_mchk;       st_tab[RK_MCHK]   = st_mchk;
    pc_tab[RK_LCRIT]  = pc_lcrit;      st_tab[RK_LCRIT]  = st_lcrit;
    pc_tab[RK_SYSRET] = pc_link;       st_tab[RK_SYSRET] = st_count;
  end

  assign sel_pc = pc_tab[kind];
  assign sel_st = st_tab[kind];

endmodule

// File: rtl/rfi_state_mask.sv
module rfi_state_mask #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]                 saved_st,
  input  logic [XLEN-1:0]                 cur_msr,
  input  logic                            tgt_wide,
  input  rfi_restore_pkg::rfi_ctl_t       ctl,
  output logic [XLEN-1:0]                 new_msr
);
  import rfi_restore_pkg::*;

  localparam int HALF = 32;

  function automatic logic [XLEN-1:0] clear_low(input logic [31:0] bits);
    logic [XLEN-1:0] t;
    t = '0;
    t[31:0] = bits;
    return ~t;
  endfunction

  function automatic logic [XLEN-1:0] keep_low(input logic [31:0] bits);
    logic [XLEN-1:0] t;
    t = '0;
    t[31:0] = bits;
    return t;
  endfunction

  function automatic logic [XLEN-1:0] pick_mask(input mask_sel_e m);
    case (m)
      MS_CLASSIC: return clear_low(CLASSIC_CLEAR);
      MS_LCRIT:   return clear_low(LCRIT_CLEAR);
      MS_LOW16:   return keep_low(LOW16_KEEP);
      default:    return '1;
    endcase
  endfunction

  logic [XLEN-1:0] masked;
  assign masked = saved_st & pick_mask(ctl.msel);

  generate
    if (XLEN > HALF) begin : g_wide
      logic [XLEN-HALF-1:0] upper;
      always_comb begin
        upper = ctl.keep_hi ? cur_msr[XLEN-1:HALF] : '0;
      end
      assign new_msr = tgt_wide ? masked : {upper, masked[HALF-1:0]};
    end else begin : g_narrow
      logic unused_narrow;
      assign unused_narrow = ^{cur_msr, tgt_wide, ctl.keep_hi};
      assign new_msr = masked;
    end
  endgenerate

  logic unused_legal;
  assign unused_legal = ctl.legal;

endmodule

// File: rtl/rfi_commit_reg.sv
module rfi_commit_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [XLEN-1:0] pc_d,
  input  logic [XLEN-1:0] msr_d,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] msr_q,
  output logic            flush_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      msr_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= accept;
      if (accept) begin
        pc_q  <= pc_d;
        msr_q <= msr_d;
      end
    end
  end

endmodule

// File: rtl/rfi_restore.sv
module rfi_restore #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rfi_valid,
  input  logic [2:0]      rfi_kind,
  input  logic [1:0]      arch_mode,
  input  logic            tgt_wide,
  input  logic [XLEN-1:0] cur_msr,
  input  logic [XLEN-1:0] save_pc_norm,
  input  logic [XLEN-1:0] save_st_norm,
  input  logic [XLEN-1:0] save_pc_hyp,
  input  logic [XLEN-1:0] save_st_hyp,
  input  logic [XLEN-1:0] save_pc_crit,
  input  logic [XLEN-1:0] save_st_crit,
  input  logic [XLEN-1:0] save_pc_dbg,
  input  logic [XLEN-1:0] save_st_dbg,
  input  logic [XLEN-1:0] save_pc_mchk,
  input  logic [XLEN-1:0] save_st_mchk,
  input  logic [XLEN-1:0] save_pc_lcrit,
  input  logic [XLEN-1:0] save_st_lcrit,
  input  logic [XLEN-1:0] link_reg,
  input  logic [XLEN-1:0] count_reg,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] next_msr,
  output logic            flush
);
  import rfi_restore_pkg::*;

  localparam logic [XLEN-1:0] PC_ALIGN = ~XLEN'(3);

  rfi_ctl_t        ctl;
  logic            accept_w;
  logic            keep_hi_w;
  logic [XLEN-1:0] sel_pc;
  logic [XLEN-1:0] sel_st;
  logic [XLEN-1:0] aligned_pc;
  logic [XLEN-1:0] masked_msr;

  assign ctl       = decode_ctl(rfi_kind, arch_mode);
  assign accept_w  = rfi_valid & ctl.legal;
  assign keep_hi_w = ctl.keep_hi;

  rfi_pair_select #(.XLEN(XLEN)) u_sel (
    .kind     (rfi_kind),
    .pc_norm  (save_pc_norm),
    .st_norm  (save_st_norm),
    .pc_hyp   (save_pc_hyp),
    .st_hyp   (save_st_hyp),
    .pc_crit  (save_pc_crit),
    .st_crit  (save_st_crit),
    .pc_dbg   (save_pc_dbg),
    .st_dbg   (save_st_dbg),
    .pc_mchk  (save_pc_mchk),
    .st_mchk  (save_st_mchk),
    .pc_lcrit (save_pc_lcrit),
    .st_lcrit (save_st_lcrit),
    .pc_link  (link_reg),
    .st_count (count_reg),
    .sel_pc   (sel_pc),
    .sel_st   (sel_st)
  );

  assign aligned_pc = sel_pc & PC_ALIGN;

  rfi_state_mask #(.XLEN(XLEN)) u_mask (
    .saved_st (sel_st),
    .cur_msr  (cur_msr),
    .tgt_wide (tgt_wide),
    .ctl      (ctl),
    .new_msr  (masked_msr)
  );

  rfi_commit_reg #(.XLEN(XLEN)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept_w),
    .pc_d    (aligned_pc),
    .msr_d   (masked_msr),
    .pc_q    (next_pc),
    .msr_q   (next_msr),
    .flush_q (flush)
  );

endmodule

// File: rtl/rfi_restore_chk.sv
module rfi_restore_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rfi_valid,
  input logic [2:0]      rfi_kind,
  input logic            tgt_wide,
  input logic            accept_w,
  input logic            keep_hi_w,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] next_msr,
  input logic            flush
);

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> next_pc[1:0] == 2'b00); // R1

  AST_FLUSH_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(rfi_valid)); // R8

  AST_ACCEPT_GIVES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> flush); // R8

  AST_RESERVED_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi_valid && rfi_kind == 3'd0) |=> !flush); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> ($stable(next_pc) && $stable(next_msr))); // R9

  AST_SYSRET_LOW16: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && $past(rfi_kind) == 3'd7) |-> next_msr[XLEN-1:16] == '0); // R6

  generate
    if (XLEN > 32) begin : g_upper
      AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && $past(!tgt_wide && !keep_hi_w)) |-> next_msr[XLEN-1:32] == '0); // R7
    end
  endgenerate

endmodule

bind rfi_restore rfi_restore_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rfi_valid (rfi_valid),
  .rfi_kind  (rfi_kind),
  .tgt_wide  (tgt_wide),
  .accept_w  (accept_w),
  .keep_hi_w (keep_hi_w),
  .next_pc   (next_pc),
  .next_msr  (next_msr),
  .flush     (flush)
);

// File: tb/tb_rfi_restore.sv
module tb_rfi_restore;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic        rfi_valid = 1'b0;
  logic [2:0]  rfi_kind = '0;
  logic [1:0]  arch_mode = '0;
  logic        tgt_wide = 1'b0;
  logic [63:0] cur_msr = '0;
  logic [63:0] sp [16];
  logic [63:0] next_pc, next_msr;
  logic        flush;

  int vectors = 0;
  int fails = 0;

  initial for (int i = 0; i < 16; i++) sp[i] = '0;

  rfi_restore dut (
    .clk(clk), .rst_n(rst_n), .rfi_valid(rfi_valid), .rfi_kind(rfi_kind),
    .arch_mode(arch_mode), .tgt_wide(tgt_wide), .cur_msr(cur_msr),
    .save_pc_norm(sp[0]), .save_st_norm(sp[1]),
    .save_pc_hyp(sp[2]), .save_st_hyp(sp[3]),
    .save_pc_crit(sp[4]), .save_st_crit(sp[5]),
    .save_pc_dbg(sp[6]), .save_st_dbg(sp[7]),
    .save_pc_mchk(sp[8]), .save_st_mchk(sp[9]),
    .save_pc_lcrit(sp[10]), .save_st_lcrit(sp[11]),
    .link_reg(sp[12]), .count_reg(sp[13]),
    .next_pc(next_pc), .next_msr(next_msr), .flush(flush)
  );

  // Behavioural reference model
  logic [63:0] exp_pc = '0, exp_msr = '0;
  logic        exp_fl = 1'b0;
  string       last_tag = "R9";
  logic        last_narrow = 1'b0;
  logic        last_keep = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    logic [63:0] raw, addr, m, v;
    logic keep, ok;
    string tag;
    if (!rst_n) begin
      exp_pc = '0; exp_msr = '0; exp_fl = 1'b0;
    end else begin
      ok = 1'b1; keep = 1'b0; m = '1; raw = '0; addr = '0; tag = "R3";
      if (rfi_kind == 3'd0) ok = 1'b0;
      else if (rfi_kind == 3'd7) begin
        addr = sp[12]; raw = sp[13]; m = 64'h0000_0000_0000_FFFF; tag = "R6";
      end else begin
        addr = sp[2*(int'(rfi_kind)-1)];
        raw  = sp[2*(int'(rfi_kind)-1)+1];
        if (rfi_kind == 3'd1) begin
          if (arch_mode == 2'd0) begin m = ~64'h783F_0000; keep = 1'b1; tag = "R2"; end
          else if (arch_mode == 2'd1) begin m = ~64'h783F_0000; tag = "R4"; end
          else if (arch_mode == 2'd3) ok = 1'b0;
        end else if (rfi_kind == 3'd2) begin m = ~64'h783F_0000; tag = "R4"; end
        else if (rfi_kind == 3'd6) begin m = ~64'hFFFF_0000; tag = "R5"; end
      end
      if (rfi_valid && ok) begin
        v = raw & m;
        if (!tgt_wide) v = {keep ? cur_msr[63:32] : 32'h0, v[31:0]};
        exp_pc = addr & ~64'h3;
        exp_msr = v;
        exp_fl = 1'b1;
        last_tag = tag;
        last_narrow = !tgt_wide;
        last_keep = keep;
      end else begin
        exp_fl = 1'b0;
        last_tag = "R9";
      end
    end
  end

  task automatic check64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check64("R8", "flush", {63'd0, flush}, {63'd0, exp_fl});
    check64(exp_fl ? "R1" : "R9", "next_pc", next_pc, exp_pc);
    check64(last_tag, "next_msr", next_msr, exp_msr);
    if (exp_fl && last_narrow && !last_keep)
      check64("R7", "msr upper half", {32'h0, next_msr[63:32]}, 64'h0);
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [1:0] md, input logic w);
    @(negedge clk);
    compare_all();
    rfi_valid = v; rfi_kind = k; arch_mode = md; tgt_wide = w;
    cur_msr = {$urandom, $urandom};
    for (int i = 0; i < 14; i++) sp[i] = {$urandom, $urandom} | 64'h3;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #5;
    // R10: reset state
    check64("R10", "reset pc", next_pc, 64'h0);
    check64("R10", "reset msr", next_msr, 64'h0);
    check64("R10", "reset flush", {63'd0, flush}, 64'h0);
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // Sweep every flavour, arch mode and target width
    for (int k = 0; k < 8; k++)
      for (int md = 0; md < 4; md++)
        for (int w = 0; w < 2; w++) begin
          drive(1'b1, 3'(k), 2'(md), w[0]);
          drive(1'b0, 3'(k), 2'(md), w[0]); // idle: R9 hold
        end
    // Back-to-back returns then random traffic
    for (int n = 0; n < 3000; n++)
      drive(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    drive(1'b0, 3'd0, 2'd0, 1'b0);
    @(negedge clk);
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule